// File: doc/BRIEF.md
# Configuration Address Translator

This block sits between a CPU-side window of 64 KiB and a conventional type-0 configuration cycle generator. For each request it joins the 16 low address bits from the CPU with the 16 upper bits held in a software-written mapping word. It then splits the joined word into its fields:

- a one-hot device-select field in bits 31 to 11;
- a function number in bits 10 to 8;
- a register number in bits 7 to 0.

The device number is the position of the lowest set bit of the device-select field. The block builds an enabled configuration address that carries the supplied bus number.

A control bit in the mapping word can switch the window off. A request made while the window is off produces no address. A read then gets an all-ones fill sized to its access width, and a write is dropped. A request whose device-select field is all zero is flagged as illegal and produces no address. Each emitted address comes with three marks: a pulse that tells the bridge to clear its two received-abort status bits, a sub-word marker, and the direction of the access. All results are registered and appear one clock after the request.

Top module: `cfg_xlate`

## Requirements
- R1: A request accepted on one rising edge produces `rsp_valid` high for exactly the following cycle. After a cycle with no request, every output is zero.
- R2: The joined address uses `map_word[15:0]` as bits 31..16 and `req_addr[15:0]` as bits 15..0.
- R3: For an emitted address, `cfg_addr[15:11]` holds the index of the lowest set bit among joined bits 31..11, where joined bit 11 is index 0.
- R4: For an emitted address, `cfg_addr[10:8]` equals joined bits 10..8 (function) and `cfg_addr[7:0]` equals joined bits 7..0 (register).
- R5: For an emitted address, `cfg_addr[31]` is 1, `cfg_addr[30:24]` is 0 and `cfg_addr[23:16]` equals `bus_num`.
- R6: When `map_word[16]` is 1, the response has `map_off`=1, `cfg_addr_vld`=0, `idsel_err`=0, `abort_clr`=0 and `cfg_addr`=0. A write in this state is therefore dropped.
- R7: `rd_fill` has ones in its low (`req_size`+1)*8 bits only for a read while `map_word[16]` is 1. Here `req_size` encodes the byte count minus one (0 for 1 byte, up to 3 for 4 bytes). In every other case `rd_fill` is zero.
- R8: With the mapping enabled and joined bits 31..11 all zero, the response has `idsel_err`=1, `cfg_addr_vld`=0 and `cfg_addr`=0. The error takes priority over emission.
- R9: `sub_word` is 1 on an emitted address exactly when `req_addr[1:0]` is nonzero. Otherwise it is 0.
- R10: `abort_clr` pulses for one cycle together with every emitted address and at no other time.
- R11: While reset is held, and in the first cycle after it is released, all outputs are zero.
- R12: `cfg_write` equals the request's `req_write` on an emitted address and is 0 otherwise.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| req_valid | input | 1 | Request strobe for one cycle |
| req_write | input | 1 | 1 for a write, 0 for a read |
| req_addr | input | 16 | CPU address offset inside the window |
| req_size | input | 2 | Access bytes minus one |
| map_word | input | 32 | Mapping word: [15:0] upper address, [16] window off |
| bus_num | input | 8 | Bus number placed in the output address |
| rsp_valid | output | 1 | Response present |
| cfg_addr_vld | output | 1 | An address was emitted |
| cfg_addr | output | 32 | Enabled configuration address |
| cfg_write | output | 1 | Direction of the emitted access |
| map_off | output | 1 | Window was switched off |
| idsel_err | output | 1 | Device-select field was empty |
| rd_fill | output | 32 | All-ones fill for reads to a switched-off window |
| sub_word | output | 1 | Emitted access has nonzero low address bits |
| abort_clr | output | 1 | Clear received master and target abort status |

## Verification
The bench builds the block with its default parameters: a 16-bit window, an 8-bit bus number and a 4-byte data path. These defaults make the device-select field 21 bits wide, so the bench walks every single-bit position from 0 to 20. It also covers multi-bit selects, where only the lowest bit must count, and an empty select. All four access sizes are exercised against a switched-off window, for both reads and writes.

// File: rtl/cfg_xlate_pkg.sv
package cfg_xlate_pkg;
  // Output address layout (decoded by the downstream cycle generator)
  localparam int OUT_W     = 32;
  localparam int EN_BIT    = 31;
  localparam int BUS_LSB   = 16;
  localparam int DEV_LSB   = 11;
  localparam int FN_LSB    = 8;
  localparam int REG_W     = 8;
  localparam int FN_W      = DEV_LSB - FN_LSB;
  localparam int SEL_W     = OUT_W - DEV_LSB;
  localparam int DEV_W     = BUS_LSB - DEV_LSB;

  typedef struct packed {
    logic             off;
    logic             err;
    logic             emit;
    logic [OUT_W-1:0] addr;
  } xl_result_t;
endpackage

// File: rtl/cfg_ctz.sv
module cfg_ctz #(
  parameter int W     = 21,
  parameter int IDX_W = (W > 1) ? $clog2(W) : 1
) (
  input  logic [W-1:0]     vec,
  output logic             any,
  output logic [IDX_W-1:0] idx
);
  logic [W-1:0] below;
  logic [W-1:0] hit;

  assign below[0] = 1'b0;
  genvar g;
  generate
    for (g = 1; g < W; g++) begin : g_chain
      assign below[g] = below[g-1] | vec[g-1];
    end
    for (g = 0; g < W; g++) begin : g_hit
      assign hit[g] = vec[g] & ~below[g];
    end
  endgenerate

  always_comb begin
    idx = '0;
    for (int i = 0; i < W; i++) begin
      if (hit[i]) idx = idx | IDX_W'(i);
    end
  end

  assign any = |vec;

  // R3: the chosen index is set and nothing below it is set
  always_comb begin
    if (any) begin
      a_r3_lowest_bit: assert (vec[idx] && ((vec & ((W'(1) << idx) - W'(1))) == '0));
    end
  end
endmodule

// File: rtl/cfg_fill_mask.sv
module cfg_fill_mask #(
  parameter int BYTES  = 4,
  parameter int SIZE_W = (BYTES > 1) ? $clog2(BYTES) : 1
) (
  input  logic              en,
  input  logic [SIZE_W-1:0] size_m1,
  output logic [BYTES*8-1:0] mask
);
  genvar b;
  generate
    for (b = 0; b < BYTES; b++) begin : g_lane
      assign mask[b*8 +: 8] = {8{en && (SIZE_W'(b) <= size_m1)}};
    end
  endgenerate
endmodule

// File: rtl/cfg_decode.sv
module cfg_decode
  import cfg_xlate_pkg::*;
#(
  parameter int APER_W  = 16,
  parameter int OFF_BIT = 16,
  parameter int BUS_W   = 8
) (
  input  logic [APER_W-1:0] low_addr,
  input  logic [31:0]       map_word,
  input  logic [BUS_W-1:0]  bus_num,
  output xl_result_t        res
);
  localparam int HI_W = OUT_W - APER_W;

  logic [OUT_W-1:0] joined;
  logic [SEL_W-1:0] sel;
  logic             sel_any;
  logic [DEV_W-1:0] dev;

  assign joined = {map_word[HI_W-1:0], low_addr};
  assign sel    = joined[OUT_W-1:DEV_LSB];

  cfg_ctz #(.W(SEL_W), .IDX_W(DEV_W)) u_ctz (
    .vec(sel), .any(sel_any), .idx(dev)
  );

  always_comb begin
    res = '0;
    res.off = map_word[OFF_BIT];
    if (!res.off) begin
      res.err  = ~sel_any;
      res.emit = sel_any;
    end
    if (res.emit) begin
      res.addr[EN_BIT]                = 1'b1;
      res.addr[BUS_LSB +: BUS_W]      = bus_num;
      res.addr[DEV_LSB +: DEV_W]      = dev;
      res.addr[FN_LSB  +: FN_W]       = joined[FN_LSB +: FN_W];
      res.addr[0 +: REG_W]            = joined[0 +: REG_W];
    end
  end
endmodule

// File: rtl/cfg_xlate.sv
module cfg_xlate
  import cfg_xlate_pkg::*;
#(
  parameter int APER_W  = 16,
  parameter int OFF_BIT = 16,
  parameter int BUS_W   = 8,
  parameter int BYTES   = 4,
  localparam int SIZE_W = (BYTES > 1) ? $clog2(BYTES) : 1,
  localparam int DATA_W = BYTES * 8
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              req_valid,
  input  logic              req_write,
  input  logic [APER_W-1:0] req_addr,
  input  logic [SIZE_W-1:0] req_size,
  input  logic [31:0]       map_word,
  input  logic [BUS_W-1:0]  bus_num,
  output logic              rsp_valid,
  output logic              cfg_addr_vld,
  output logic [OUT_W-1:0]  cfg_addr,
  output logic              cfg_write,
  output logic              map_off,
  output logic              idsel_err,
  output logic [DATA_W-1:0] rd_fill,
  output logic              sub_word,
  output logic              abort_clr
);
  xl_result_t        res;
  logic [DATA_W-1:0] fill_n;

  cfg_decode #(.APER_W(APER_W), .OFF_BIT(OFF_BIT), .BUS_W(BUS_W)) u_dec (
    .low_addr(req_addr), .map_word(map_word), .bus_num(bus_num), .res(res)
  );

  cfg_fill_mask #(.BYTES(BYTES), .SIZE_W(SIZE_W)) u_fill (
    .en(res.off && !req_write), .size_m1(req_size), .mask(fill_n)
  );

  always_ff @(posedge clk) begin
    if (rst || !req_valid) begin
      rsp_valid    <= 1'b0;
      cfg_addr_vld <= 1'b0;
      cfg_addr     <= '0;
      cfg_write    <= 1'b0;
      map_off      <= 1'b0;
      idsel_err    <= 1'b0;
      rd_fill      <= '0;
      sub_word     <= 1'b0;
      abort_clr    <= 1'b0;
    end else begin
      rsp_valid    <= 1'b1;
      cfg_addr_vld <= res.emit;
      cfg_addr     <= res.addr;
      cfg_write    <= res.emit & req_write;
      map_off      <= res.off;
      idsel_err    <= res.err;
      rd_fill      <= fill_n;
      sub_word     <= res.emit & (req_addr[1:0] != 2'b00);
      abort_clr    <= res.emit;
    end
  end

  a_r1_latency: assert property (@(posedge clk) disable iff (rst)
    req_valid |=> rsp_valid);
  a_r1_idle: assert property (@(posedge clk) disable iff (rst)
    !req_valid |=> !rsp_valid && !cfg_addr_vld && !map_off && !idsel_err);
  a_r5_enable_bit: assert property (@(posedge clk) disable iff (rst)
    cfg_addr_vld |-> cfg_addr[EN_BIT] && cfg_addr[30:24] == '0);
  a_r6_off_quiet: assert property (@(posedge clk) disable iff (rst)
    map_off |-> !cfg_addr_vld && !idsel_err && !abort_clr);
  a_r7_fill_only_off: assert property (@(posedge clk) disable iff (rst)
    (rd_fill != '0) |-> map_off && !cfg_write);
  a_r8_err_wins: assert property (@(posedge clk) disable iff (rst)
    idsel_err |-> !cfg_addr_vld && cfg_addr == '0);
  a_r10_clear_pulse: assert property (@(posedge clk) disable iff (rst)
    abort_clr |-> cfg_addr_vld && rsp_valid);
endmodule

// File: tb/sim_cfg_xlate.sv
module sim_cfg_xlate;
  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic        req_valid = 1'b0, req_write = 1'b0;
  logic [15:0] req_addr = '0;
  logic [1:0]  req_size = '0;
  logic [31:0] map_word = '0;
  logic [7:0]  bus_num = '0;
  logic        rsp_valid, cfg_addr_vld, cfg_write, map_off, idsel_err, sub_word, abort_clr;
  logic [31:0] cfg_addr, rd_fill;

  int checks = 0, failures = 0;
  logic        e_rv = 0, e_vld = 0, e_wr = 0, e_off = 0, e_err = 0, e_sub = 0, e_clr = 0;
  logic [31:0] e_addr = 0, e_fill = 0;

  always #2 clk = ~clk;

  cfg_xlate u0 (
    .clk(clk), .rst(rst), .req_valid(req_valid), .req_write(req_write),
    .req_addr(req_addr), .req_size(req_size), .map_word(map_word), .bus_num(bus_num),
    .rsp_valid(rsp_valid), .cfg_addr_vld(cfg_addr_vld), .cfg_addr(cfg_addr),
    .cfg_write(cfg_write), .map_off(map_off), .idsel_err(idsel_err),
    .rd_fill(rd_fill), .sub_word(sub_word), .abort_clr(abort_clr)
  );

  task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      failures++;
      $display("FAIL %s actual=%h expected=%h at %0t", tag, act, exp, $time);
    end
  endtask

  task automatic compare_all();
    chk("R1 rsp_valid", 32'(rsp_valid), 32'(e_rv));
    chk("R3 R4 R5 cfg_addr", cfg_addr, e_addr);
    chk("R8 cfg_addr_vld", 32'(cfg_addr_vld), 32'(e_vld));
    chk("R6 map_off", 32'(map_off), 32'(e_off));
    chk("R8 idsel_err", 32'(idsel_err), 32'(e_err));
    chk("R7 rd_fill", rd_fill, e_fill);
    chk("R9 sub_word", 32'(sub_word), 32'(e_sub));
    chk("R10 abort_clr", 32'(abort_clr), 32'(e_clr));
    chk("R12 cfg_write", 32'(cfg_write), 32'(e_wr));
  endtask

  // Reference model: behavioural, from the requirements
  task automatic step(input logic r, input logic v, input logic w, input logic [15:0] a,
                      input logic [31:0] m, input logic [7:0] b, input logic [1:0] s);
    logic [31:0] joined;
    int dev;
    @(negedge clk);
    compare_all();
    rst = r; req_valid = v; req_write = w; req_addr = a; map_word = m; bus_num = b; req_size = s;
    e_rv = 0; e_vld = 0; e_wr = 0; e_off = 0; e_err = 0; e_sub = 0; e_clr = 0;
    e_addr = 0; e_fill = 0;
    if (!r && v) begin
      e_rv = 1;
      joined = {m[15:0], a};                       // R2
      if (m[16]) begin
        e_off = 1;                                 // R6
        if (!w) e_fill = (33'd1 << ((int'(s) + 1) * 8)) - 33'd1;   // R7
      end else if (joined[31:11] == 0) begin
        e_err = 1;                                 // R8
      end else begin
        dev = -1;
        for (int i = 0; i < 21; i++) if (dev < 0 && joined[11 + i]) dev = i;
        e_vld = 1; e_clr = 1; e_wr = w;
        e_sub = (a[1:0] != 0);
        e_addr = 32'h8000_0000 | (32'(b) << 16) | (32'(dev) << 11) | 32'(joined[10:0]);
      end
    end
  endtask

  initial begin : watchdog
    #400000;
    failures++;
    $display("FAIL watchdog expired");
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end

  initial begin
    // R11: reset held with a request present
    step(1, 1, 0, 16'h1234, 32'h0000_0001, 8'h5, 2'd3);
    step(1, 1, 0, 16'h1234, 32'h0000_0001, 8'h5, 2'd3);
    step(0, 0, 0, 0, 0, 0, 0);                    // R11: first cycle after release
    // R3: every single select position, bits in low half (pos 0..4) and upper half
    for (int p = 0; p < 21; p++) begin
      logic [31:0] j;
      j = (32'd1 << (11 + p)) | 32'h0000_02A5;
      step(0, 1, p[0], j[15:0], {16'h0, j[31:16]}, 8'(p * 7), 2'(p));
    end
    // R3: multi-bit select, lowest wins
    step(0, 1, 0, 16'hF800 | 16'h0033, 32'h0000_FFFF, 8'hA5, 2'd2);
    step(0, 1, 1, 16'h0000, 32'h0000_8030, 8'hFF, 2'd0);
    // R8: empty select
    step(0, 1, 0, 16'h07FF, 32'h0000_0000, 8'h12, 2'd3);
    step(0, 1, 1, 16'h0001, 32'h0000_0000, 8'h12, 2'd1);
    // R6 R7: window off, reads of every size then writes
    for (int s = 0; s < 4; s++) step(0, 1, 0, 16'hFFFF, 32'h0001_0004, 8'h3, 2'(s));
    for (int s = 0; s < 4; s++) step(0, 1, 1, 16'h0800, 32'h0001_0000, 8'h3, 2'(s));
    // R9: sub-word offsets
    for (int o = 0; o < 4; o++) step(0, 1, 0, 16'h4810 | 16'(o), 32'h0, 8'h9, 2'd0);
    // R1: idle gaps interleaved
    step(0, 0, 1, 16'h4800, 32'h0, 8'h1, 2'd0);
    step(0, 1, 1, 16'h4800, 32'h0, 8'h1, 2'd0);
    step(0, 0, 0, 16'h4800, 32'h0, 8'h1, 2'd0);
    // random mix
    for (int n = 0; n < 3000; n++) begin
      logic [31:0] m;
      m = $urandom;
      if ((n % 5) == 0) m[15:0] = 0;
      if ((n % 3) != 0) m[16] = 0;
      step(0, ($urandom % 4) != 0, 1'($urandom), 16'($urandom), m, 8'($urandom), 2'($urandom));
    end
    // reset mid-stream
    step(1, 1, 1, 16'h8000, 32'h0, 8'h1, 2'd0);
    step(0, 0, 0, 0, 0, 0, 0);
    step(0, 0, 0, 0, 0, 0, 0);
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end
endmodule